// File: doc/BRIEF.md
# CAN transmit mailbox arbiter

This block sits between a bank of transmit mailboxes and the transmit buffer of a CAN protocol engine. The host marks mailboxes as ready to send. Whenever at least one mailbox is pending and the engine is free, the block picks the most urgent message, meaning the lowest identifier, with the lower mailbox number winning a tie. It then copies that mailbox's words from the shared mailbox RAM into the engine's transmit buffer and raises a start strobe.

The engine reports each attempt as either sent or lost. A sent frame clears the pending bit and raises the mailbox's acknowledge bit. A lost frame keeps the mailbox pending, and the block selects again, so a more urgent message that arrived in the meantime goes first. The host may cancel pending mailboxes. A mailbox that is not in flight is withdrawn at once and its abort-acknowledge bit is raised. For the mailbox in flight, the cancel is held until the engine reports the outcome.

The mailbox RAM has a single port. The host uses it through a request/grant pair. The controller takes the port for the whole of a buffer load, so a host access waits at most one load.

Top module: `can_tx_arbiter`

## Requirements
- R1: Among pending mailboxes the one with the numerically lowest identifier is loaded. On equal identifiers the lower mailbox number wins.
- R2: A load reads the WORDS words of mailbox m from RAM addresses m*WORDS+k for k = 0..WORDS-1, in that order. Each word appears on txb_data with txb_wr high and txb_word = k, one cycle after its read. tx_start is high together with the last word, and tx_mb_idx holds m from the start of the load until the outcome is reported.
- R3: Transmission is event-triggered. With the engine idle, setting a pending bit makes tx_start rise WORDS+1 clock edges after the write edge. A load never starts in a cycle that has a host register write, and tx_start never rises while nothing is pending.
- R4: can_done while a frame is in flight clears that mailbox's pending bit and sets its acknowledge bit on the same edge.
- R5: can_lost while a frame is in flight leaves its pending bit set. Selection runs again, including any mailboxes that became pending meanwhile.
- R6: A cancel (host_reg_op = 1) for a pending mailbox that is not in flight clears its pending bit and sets its abort-acknowledge bit on the write edge.
- R7: A cancel for the mailbox in flight sets its cancel bit, and the mailbox stays pending. can_done then sets the acknowledge bit and leaves abort-acknowledge clear. can_lost instead clears the pending bit and sets abort-acknowledge. Either outcome clears the cancel bit, so at most one cancel bit is ever set.
- R8: A cancel for a mailbox that is not pending changes no flag.
- R9: Host register operations act on the mailboxes whose bit is set in host_reg_mask. The codes are: 0 sets pending, 1 requests cancel, 2 clears acknowledge, 3 clears abort-acknowledge. Clears affect only the masked bits.
- R10: A host RAM request is granted in the same cycle unless a load is reading RAM. Granted writes update the RAM. Granted reads return data on ram_rdata in the next cycle, with host_ram_rvalid high.
- R11: A held host request waits at most WORDS cycles for its grant.
- R12: After reset all flag vectors are zero, tx_start and txb_wr are low and tx_mb_idx is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_reg_wr | input | 1 | Host flag register operation strobe |
| host_reg_op | input | 2 | Operation code (see R9) |
| host_reg_mask | input | NUM_MB | Mailboxes the operation acts on |
| id_wr | input | 1 | Identifier shadow write strobe |
| id_wr_mb | input | MB_W | Mailbox whose identifier is written |
| id_wr_val | input | ID_W | Identifier value |
| host_ram_req | input | 1 | Host RAM access request |
| host_ram_we | input | 1 | Host access is a write |
| host_ram_addr | input | ADDR_W | Host RAM address |
| host_ram_wdata | input | DATA_W | Host write data |
| host_ram_gnt | output | 1 | Host access performed this cycle |
| host_ram_rvalid | output | 1 | Host read data valid on ram_rdata |
| ram_en | output | 1 | RAM port enable |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | ADDR_W | RAM address |
| ram_wdata | output | DATA_W | RAM write data |
| ram_rdata | input | DATA_W | RAM read data, one cycle latency |
| txb_wr | output | 1 | Transmit buffer word load strobe |
| txb_word | output | WW | Word index within the buffer |
| txb_data | output | DATA_W | Word loaded into the buffer |
| tx_start | output | 1 | Buffer complete, engine may send |
| tx_mb_idx | output | MB_W | Selected mailbox |
| can_done | input | 1 | Engine: frame sent |
| can_lost | input | 1 | Engine: arbitration lost, frame not sent |
| pend_vec | output | NUM_MB | Transmit pending flags |
| cancel_vec | output | NUM_MB | Held cancel flags |
| ack_vec | output | NUM_MB | Transmit acknowledge flags |
| aback_vec | output | NUM_MB | Abort acknowledge flags |

## Verification
The bench sets up two mailboxes with equal identifiers and a tie the wrong way round. A selector that compares with "less or equal" or walks from the top would load mailbox 9 before 7. A lost arbitration is followed by a more urgent arrival: a design that retried the old frame without reselecting would send mailbox 5 again, and one that dropped the pending bit would never send it. Cancels go to an idle mailbox, to the one in flight with a sent outcome and with a lost outcome, and to a non-pending mailbox. A wrong split between immediate and deferred cancel shows up as a stray acknowledge or abort-acknowledge, or as a lost frame. A host read is issued during a load: a design that granted it would corrupt the buffer words, and one that never granted it would break the stall bound.

// File: rtl/can_txarb_pkg.sv
package can_txarb_pkg;

   typedef enum logic [1:0] {
      OP_SET_PEND  = 2'd0,
      OP_CANCEL    = 2'd1,
      OP_CLR_ACK   = 2'd2,
      OP_CLR_ABACK = 2'd3
   } host_op_e;

   typedef enum logic [1:0] {
      SQ_IDLE  = 2'd0,
      SQ_LOAD  = 2'd1,
      SQ_FLUSH = 2'd2,
      SQ_WAIT  = 2'd3
   } seq_state_e;

endpackage

// File: rtl/can_txarb_prio.sv
module can_txarb_prio #(
   parameter int NUM_MB = 32,
   parameter int ID_W   = 11,
   localparam int MB_W  = $clog2(NUM_MB)
) (
   input  logic [NUM_MB-1:0]      req,
   input  logic [NUM_MB*ID_W-1:0] ids_flat,
   output logic                   any,
   output logic [MB_W-1:0]        win
);
   localparam int LEAVES = 1 << MB_W;
   localparam int NODES  = 2 * LEAVES - 1;

   logic            node_v  [NODES];
   logic [ID_W-1:0] node_id [NODES];
   logic [MB_W-1:0] node_ix [NODES];

   if (NUM_MB < 2) begin : g_bad_cnt
      $error("can_txarb_prio: NUM_MB must be at least 2");
   end

   for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
      if (i < NUM_MB) begin : g_real
         assign node_v [LEAVES-1+i] = req[i];
         assign node_id[LEAVES-1+i] = ids_flat[i*ID_W +: ID_W];
         assign node_ix[LEAVES-1+i] = MB_W'(i);
      end else begin : g_pad
         assign node_v [LEAVES-1+i] = 1'b0;
         assign node_id[LEAVES-1+i] = '1;
         assign node_ix[LEAVES-1+i] = MB_W'(i);
      end
   end

   // Left child always covers lower mailbox numbers, so it keeps ties.
   for (genvar n = 0; n < LEAVES - 1; n++) begin : g_node
      logic take_r;
      assign take_r = node_v[2*n+2] &&
                      (!node_v[2*n+1] || (node_id[2*n+2] < node_id[2*n+1]));
      assign node_v [n] = node_v[2*n+1] || node_v[2*n+2];
      assign node_id[n] = take_r ? node_id[2*n+2] : node_id[2*n+1];
      assign node_ix[n] = take_r ? node_ix[2*n+2] : node_ix[2*n+1];
   end

   assign any = node_v[0];
   assign win = node_ix[0];

endmodule

// File: rtl/can_txarb_flags.sv
module can_txarb_flags
   import can_txarb_pkg::*;
#(
   parameter int NUM_MB = 32,
   localparam int MB_W  = $clog2(NUM_MB)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  host_op_e          reg_op,
   input  logic [NUM_MB-1:0] reg_mask,
   input  logic              busy,
   input  logic [MB_W-1:0]   cur_idx,
   input  logic              fin_ok,
   input  logic              fin_lost,
   output logic [NUM_MB-1:0] pend_q,
   output logic [NUM_MB-1:0] cancel_q,
   output logic [NUM_MB-1:0] ack_q,
   output logic [NUM_MB-1:0] aback_q
);

   for (genvar i = 0; i < NUM_MB; i++) begin : g_bit
      logic hit, inflt, done_i, lost_i, cx_now, cx_defer;

      assign hit      = reg_wr && reg_mask[i];
      assign inflt    = busy && (cur_idx == MB_W'(i));
      assign done_i   = fin_ok && inflt;
      assign lost_i   = fin_lost && inflt;
      assign cx_now   = hit && (reg_op == OP_CANCEL) && pend_q[i] && !inflt;
      assign cx_defer = hit && (reg_op == OP_CANCEL) && pend_q[i] && inflt;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            pend_q[i]   <= 1'b0;
            cancel_q[i] <= 1'b0;
            ack_q[i]    <= 1'b0;
            aback_q[i]  <= 1'b0;
         end else begin
            if (done_i || (lost_i && cancel_q[i]) || cx_now)
               pend_q[i] <= 1'b0;
            else if (hit && (reg_op == OP_SET_PEND))
               pend_q[i] <= 1'b1;

            if (done_i || lost_i)
               cancel_q[i] <= 1'b0;
            else if (cx_defer)
               cancel_q[i] <= 1'b1;

            if (done_i)
               ack_q[i] <= 1'b1;
            else if (hit && (reg_op == OP_CLR_ACK))
               ack_q[i] <= 1'b0;

            if ((lost_i && cancel_q[i]) || cx_now)
               aback_q[i] <= 1'b1;
            else if (hit && (reg_op == OP_CLR_ABACK))
               aback_q[i] <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/can_txarb_seq.sv
module can_txarb_seq
   import can_txarb_pkg::*;
#(
   parameter int NUM_MB = 32,
   parameter int WORDS  = 4,
   parameter int DATA_W = 32,
   localparam int MB_W   = $clog2(NUM_MB),
   localparam int WW     = $clog2(WORDS),
   localparam int ADDR_W = $clog2(NUM_MB * WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              any_req,
   input  logic [MB_W-1:0]   win,
   input  logic              reg_wr,
   input  logic              can_done,
   input  logic              can_lost,
   input  logic              host_ram_req,
   input  logic              host_ram_we,
   input  logic [ADDR_W-1:0] host_ram_addr,
   input  logic [DATA_W-1:0] host_ram_wdata,
   input  logic [DATA_W-1:0] ram_rdata,
   output logic              host_ram_gnt,
   output logic              host_ram_rvalid,
   output logic              ram_en,
   output logic              ram_we,
   output logic [ADDR_W-1:0] ram_addr,
   output logic [DATA_W-1:0] ram_wdata,
   output logic              txb_wr,
   output logic [WW-1:0]     txb_word,
   output logic [DATA_W-1:0] txb_data,
   output logic              tx_start,
   output logic              busy,
   output logic [MB_W-1:0]   cur_idx,
   output logic              fin_ok,
   output logic              fin_lost
);
   seq_state_e        state_q, state_d;
   logic [MB_W-1:0]   sel_q;
   logic [WW-1:0]     cnt_q;
   logic              rd_v_q;
   logic [WW-1:0]     rd_ix_q;
   logic              rvalid_q;
   logic              load_act;
   logic              start_now;
   logic [ADDR_W-1:0] ctrl_addr;

   assign load_act  = (state_q == SQ_LOAD);
   assign start_now = (state_q == SQ_IDLE) && any_req && !reg_wr;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         SQ_IDLE:  if (start_now) state_d = SQ_LOAD;
         SQ_LOAD:  if (cnt_q == WW'(WORDS - 1)) state_d = SQ_FLUSH;
         SQ_FLUSH: state_d = SQ_WAIT;
         SQ_WAIT:  if (can_done || can_lost) state_d = SQ_IDLE;
         default:  state_d = SQ_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= SQ_IDLE;
         sel_q    <= '0;
         cnt_q    <= '0;
         rd_v_q   <= 1'b0;
         rd_ix_q  <= '0;
         rvalid_q <= 1'b0;
      end else begin
         state_q  <= state_d;
         rd_v_q   <= load_act;
         rd_ix_q  <= cnt_q;
         rvalid_q <= host_ram_gnt && !host_ram_we;
         if (start_now) begin
            sel_q <= win;
            cnt_q <= '0;
         end else if (load_act) begin
            cnt_q <= cnt_q + WW'(1);
         end
      end
   end

   // A power-of-two mailbox size needs no multiplier for the address.
   if ((WORDS & (WORDS - 1)) == 0) begin : g_addr_cat
      assign ctrl_addr = ADDR_W'({sel_q, cnt_q});
   end else begin : g_addr_mul
      assign ctrl_addr = ADDR_W'(sel_q) * ADDR_W'(WORDS) + ADDR_W'(cnt_q);
   end

   assign host_ram_gnt    = host_ram_req && !load_act;
   assign host_ram_rvalid = rvalid_q;
   assign ram_en          = load_act || host_ram_gnt;
   assign ram_we          = host_ram_gnt && host_ram_we;
   assign ram_addr        = load_act ? ctrl_addr : host_ram_addr;
   assign ram_wdata       = host_ram_wdata;

   assign txb_wr   = rd_v_q;
   assign txb_word = rd_ix_q;
   assign txb_data = ram_rdata;
   assign tx_start = (state_q == SQ_FLUSH);

   assign busy     = (state_q != SQ_IDLE);
   assign cur_idx  = sel_q;
   assign fin_ok   = (state_q == SQ_WAIT) && can_done;
   assign fin_lost = (state_q == SQ_WAIT) && can_lost && !can_done;

endmodule

// File: rtl/can_tx_arbiter.sv
module can_tx_arbiter
   import can_txarb_pkg::*;
#(
   parameter int NUM_MB = 32,
   parameter int ID_W   = 11,
   parameter int WORDS  = 4,
   parameter int DATA_W = 32,
   localparam int MB_W   = $clog2(NUM_MB),
   localparam int WW     = $clog2(WORDS),
   localparam int ADDR_W = $clog2(NUM_MB * WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_reg_wr,
   input  logic [1:0]        host_reg_op,
   input  logic [NUM_MB-1:0] host_reg_mask,
   input  logic              id_wr,
   input  logic [MB_W-1:0]   id_wr_mb,
   input  logic [ID_W-1:0]   id_wr_val,
   input  logic              host_ram_req,
   input  logic              host_ram_we,
   input  logic [ADDR_W-1:0] host_ram_addr,
   input  logic [DATA_W-1:0] host_ram_wdata,
   output logic              host_ram_gnt,
   output logic              host_ram_rvalid,
   output logic              ram_en,
   output logic              ram_we,
   output logic [ADDR_W-1:0] ram_addr,
   output logic [DATA_W-1:0] ram_wdata,
   input  logic [DATA_W-1:0] ram_rdata,
   output logic              txb_wr,
   output logic [WW-1:0]     txb_word,
   output logic [DATA_W-1:0] txb_data,
   output logic              tx_start,
   output logic [MB_W-1:0]   tx_mb_idx,
   input  logic              can_done,
   input  logic              can_lost,
   output logic [NUM_MB-1:0] pend_vec,
   output logic [NUM_MB-1:0] cancel_vec,
   output logic [NUM_MB-1:0] ack_vec,
   output logic [NUM_MB-1:0] aback_vec
);

   if (NUM_MB < 2 || NUM_MB > 64) begin : g_bad_mb
      $error("can_tx_arbiter: NUM_MB must lie in 2..64");
   end
   if (WORDS < 2) begin : g_bad_words
      $error("can_tx_arbiter: WORDS must be at least 2");
   end
   if (ID_W < 1 || ID_W > 29) begin : g_bad_id
      $error("can_tx_arbiter: ID_W must lie in 1..29");
   end

   logic [NUM_MB*ID_W-1:0] ids_flat;
   logic                   any_req;
   logic [MB_W-1:0]        win;
   logic                   busy, fin_ok, fin_lost;
   logic [MB_W-1:0]        cur_idx;

   // Identifier shadow, one register per mailbox, feeds the selector.
   for (genvar i = 0; i < NUM_MB; i++) begin : g_id
      logic [ID_W-1:0] id_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            id_q <= '0;
         else if (id_wr && (id_wr_mb == MB_W'(i)))
            id_q <= id_wr_val;
      end
      assign ids_flat[i*ID_W +: ID_W] = id_q;
   end

   can_txarb_prio #(.NUM_MB(NUM_MB), .ID_W(ID_W)) u_prio (
      .req      (pend_vec),
      .ids_flat (ids_flat),
      .any      (any_req),
      .win      (win)
   );

   can_txarb_flags #(.NUM_MB(NUM_MB)) u_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .reg_wr   (host_reg_wr),
      .reg_op   (host_op_e'(host_reg_op)),
      .reg_mask (host_reg_mask),
      .busy     (busy),
      .cur_idx  (cur_idx),
      .fin_ok   (fin_ok),
      .fin_lost (fin_lost),
      .pend_q   (pend_vec),
      .cancel_q (cancel_vec),
      .ack_q    (ack_vec),
      .aback_q  (aback_vec)
   );

   can_txarb_seq #(.NUM_MB(NUM_MB), .WORDS(WORDS), .DATA_W(DATA_W)) u_seq (
      .clk             (clk),
      .rst_n           (rst_n),
      .any_req         (any_req),
      .win             (win),
      .reg_wr          (host_reg_wr),
      .can_done        (can_done),
      .can_lost        (can_lost),
      .host_ram_req    (host_ram_req),
      .host_ram_we     (host_ram_we),
      .host_ram_addr   (host_ram_addr),
      .host_ram_wdata  (host_ram_wdata),
      .ram_rdata       (ram_rdata),
      .host_ram_gnt    (host_ram_gnt),
      .host_ram_rvalid (host_ram_rvalid),
      .ram_en          (ram_en),
      .ram_we          (ram_we),
      .ram_addr        (ram_addr),
      .ram_wdata       (ram_wdata),
      .txb_wr          (txb_wr),
      .txb_word        (txb_word),
      .txb_data        (txb_data),
      .tx_start        (tx_start),
      .busy            (busy),
      .cur_idx         (cur_idx),
      .fin_ok          (fin_ok),
      .fin_lost        (fin_lost)
   );

   assign tx_mb_idx = cur_idx;

endmodule

// File: rtl/can_txarb_chk.sv
module can_txarb_chk #(
   parameter int NUM_MB = 32,
   parameter int WORDS  = 4,
   parameter int ADDR_W = 7,
   parameter int WW     = 2,
   parameter int MB_W   = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              host_ram_req,
   input logic              host_ram_gnt,
   input logic [ADDR_W-1:0] host_ram_addr,
   input logic              ram_en,
   input logic [ADDR_W-1:0] ram_addr,
   input logic              txb_wr,
   input logic [WW-1:0]     txb_word,
   input logic              tx_start,
   input logic [MB_W-1:0]   tx_mb_idx,
   input logic              can_done,
   input logic              can_lost,
   input logic [NUM_MB-1:0] pend_vec,
   input logic [NUM_MB-1:0] cancel_vec,
   input logic [NUM_MB-1:0] ack_vec
);
   logic       wait_q;
   logic [7:0] stall_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wait_q  <= 1'b0;
         stall_q <= '0;
      end else begin
         if (tx_start)
            wait_q <= 1'b1;
         else if (can_done || can_lost)
            wait_q <= 1'b0;
         if (host_ram_req && !host_ram_gnt)
            stall_q <= (stall_q == 8'hFF) ? stall_q : stall_q + 8'd1;
         else
            stall_q <= '0;
      end
   end

   p_start_pending_r1: assert property (@(posedge clk) disable iff (!rst_n)
      tx_start |-> pend_vec[tx_mb_idx]);

   p_start_last_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
      tx_start |-> (txb_wr && (txb_word == WW'(WORDS - 1))));

   p_done_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wait_q && can_done) |=> (ack_vec[$past(tx_mb_idx)] && !pend_vec[$past(tx_mb_idx)]));

   p_lost_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wait_q && can_lost && !can_done && !cancel_vec[tx_mb_idx]) |=> pend_vec[$past(tx_mb_idx)]);

   p_one_cancel_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cancel_vec));

   p_host_path_r10: assert property (@(posedge clk) disable iff (!rst_n)
      host_ram_gnt |-> (ram_en && (ram_addr == host_ram_addr)));

   p_stall_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
      stall_q <= 8'(WORDS));

endmodule

bind can_tx_arbiter can_txarb_chk #(
   .NUM_MB (NUM_MB),
   .WORDS  (WORDS),
   .ADDR_W (ADDR_W),
   .WW     (WW),
   .MB_W   (MB_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .host_ram_req  (host_ram_req),
   .host_ram_gnt  (host_ram_gnt),
   .host_ram_addr (host_ram_addr),
   .ram_en        (ram_en),
   .ram_addr      (ram_addr),
   .txb_wr        (txb_wr),
   .txb_word      (txb_word),
   .tx_start      (tx_start),
   .tx_mb_idx     (tx_mb_idx),
   .can_done      (can_done),
   .can_lost      (can_lost),
   .pend_vec      (pend_vec),
   .cancel_vec    (cancel_vec),
   .ack_vec       (ack_vec)
);

// File: tb/can_tx_arbiter_tb.sv
module can_tx_arbiter_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NUM_MB = 32;
   localparam int ID_W   = 11;
   localparam int WORDS  = 4;
   localparam int DATA_W = 32;
   localparam int MB_W   = 5;
   localparam int WW     = 2;
   localparam int ADDR_W = 7;
   localparam int MEM_N  = NUM_MB * WORDS;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              host_reg_wr = 1'b0;
   logic [1:0]        host_reg_op = '0;
   logic [NUM_MB-1:0] host_reg_mask = '0;
   logic              id_wr = 1'b0;
   logic [MB_W-1:0]   id_wr_mb = '0;
   logic [ID_W-1:0]   id_wr_val = '0;
   logic              host_ram_req = 1'b0;
   logic              host_ram_we = 1'b0;
   logic [ADDR_W-1:0] host_ram_addr = '0;
   logic [DATA_W-1:0] host_ram_wdata = '0;
   logic              host_ram_gnt, host_ram_rvalid;
   logic              ram_en, ram_we;
   logic [ADDR_W-1:0] ram_addr;
   logic [DATA_W-1:0] ram_wdata;
   logic [DATA_W-1:0] ram_rdata = '0;
   logic              txb_wr;
   logic [WW-1:0]     txb_word;
   logic [DATA_W-1:0] txb_data;
   logic              tx_start;
   logic [MB_W-1:0]   tx_mb_idx;
   logic              can_done = 1'b0;
   logic              can_lost = 1'b0;
   logic [NUM_MB-1:0] pend_vec, cancel_vec, ack_vec, aback_vec;

   int tests = 0;
   int fails = 0;
   int cycles = 0;

   logic [DATA_W-1:0] mem [MEM_N];
   logic [DATA_W-1:0] cap [WORDS];

   always #(CLK_PERIOD / 2) clk = ~clk;

   can_tx_arbiter #(.NUM_MB(NUM_MB), .ID_W(ID_W), .WORDS(WORDS), .DATA_W(DATA_W)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .host_reg_wr(host_reg_wr), .host_reg_op(host_reg_op), .host_reg_mask(host_reg_mask),
      .id_wr(id_wr), .id_wr_mb(id_wr_mb), .id_wr_val(id_wr_val),
      .host_ram_req(host_ram_req), .host_ram_we(host_ram_we),
      .host_ram_addr(host_ram_addr), .host_ram_wdata(host_ram_wdata),
      .host_ram_gnt(host_ram_gnt), .host_ram_rvalid(host_ram_rvalid),
      .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr),
      .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
      .txb_wr(txb_wr), .txb_word(txb_word), .txb_data(txb_data),
      .tx_start(tx_start), .tx_mb_idx(tx_mb_idx),
      .can_done(can_done), .can_lost(can_lost),
      .pend_vec(pend_vec), .cancel_vec(cancel_vec),
      .ack_vec(ack_vec), .aback_vec(aback_vec)
   );

   // Single-port RAM model, one cycle read latency, filled during reset.
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < MEM_N; i++) mem[i] <= 32'hC0DE_0000 + i;
      end else if (ram_en) begin
         if (ram_we) mem[ram_addr] <= ram_wdata;
         else        ram_rdata <= mem[ram_addr];
      end
   end

   always @(posedge clk) if (txb_wr) cap[txb_word] <= txb_data;

   function automatic logic [DATA_W-1:0] pat(input int a);
      return 32'hC0DE_0000 + a;
   endfunction

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic reg_op(input logic [1:0] op, input logic [NUM_MB-1:0] mask);
      @(negedge clk);
      host_reg_wr = 1'b1; host_reg_op = op; host_reg_mask = mask;
      @(negedge clk);
      host_reg_wr = 1'b0; host_reg_mask = '0;
   endtask

   task automatic set_id(input int mb, input int id);
      @(negedge clk);
      id_wr = 1'b1; id_wr_mb = MB_W'(mb); id_wr_val = ID_W'(id);
      @(negedge clk);
      id_wr = 1'b0;
   endtask

   task automatic wait_start(output int idx, output int lat);
      lat = 0;
      while (!tx_start && lat < 40) begin
         @(negedge clk);
         lat++;
      end
      idx = int'(tx_mb_idx);
   endtask

   task automatic check_words(input string tag, input int mb);
      @(negedge clk);
      for (int k = 0; k < WORDS; k++)
         check(tag, cap[k], pat(mb * WORDS + k));
   endtask

   task automatic engine_done();
      @(negedge clk); can_done = 1'b1;
      @(negedge clk); can_done = 1'b0;
   endtask

   task automatic engine_lost();
      @(negedge clk); can_lost = 1'b1;
      @(negedge clk); can_lost = 1'b0;
   endtask

   task automatic t_reset();
      check("R12 pend", pend_vec, 0);
      check("R12 cancel", cancel_vec, 0);
      check("R12 ack", ack_vec, 0);
      check("R12 aback", aback_vec, 0);
      check("R12 tx_start/txb_wr", {tx_start, txb_wr}, 0);
      check("R12 tx_mb_idx", tx_mb_idx, 0);
   endtask

   task automatic t_priority();
      int idx, lat;
      set_id(2, 'h100); set_id(7, 'h050); set_id(9, 'h050); set_id(20, 'h7FF);
      reg_op(2'd0, (32'd1 << 2) | (32'd1 << 7) | (32'd1 << 9) | (32'd1 << 20));
      wait_start(idx, lat);
      check("R3 start latency", lat, WORDS + 1);
      check("R1 lowest id, tie to lower mailbox", idx, 7);
      check_words("R2 buffer words mb7", 7);
      engine_done();
      check("R4 ack set mb7", ack_vec[7], 1);
      check("R4 pend clear mb7", pend_vec[7], 0);
      wait_start(idx, lat);
      check("R1 second pick", idx, 9);
      engine_done();
      wait_start(idx, lat);
      check("R1 third pick", idx, 2);
      check_words("R2 buffer words mb2", 2);
      engine_done();
      wait_start(idx, lat);
      check("R1 fourth pick", idx, 20);
      engine_done();
      check("R4 all pending cleared", pend_vec, 0);
      check("R4 ack set", ack_vec, (32'd1 << 2) | (32'd1 << 7) | (32'd1 << 9) | (32'd1 << 20));
   endtask

   task automatic t_idle_and_clear();
      int seen = 0;
      for (int c = 0; c < 12; c++) begin
         @(negedge clk);
         if (tx_start) seen++;
      end
      check("R3 no start while idle", seen, 0);
      reg_op(2'd2, (32'd1 << 7) | (32'd1 << 9));
      check("R9 clear ack masked only", ack_vec, (32'd1 << 2) | (32'd1 << 20));
   endtask

   task automatic t_lost();
      int idx, lat;
      set_id(5, 'h200); set_id(3, 'h010);
      reg_op(2'd0, 32'd1 << 5);
      wait_start(idx, lat);
      check("R5 first load mb5", idx, 5);
      reg_op(2'd0, 32'd1 << 3);
      engine_lost();
      check("R5 pend kept after lost", pend_vec[5], 1);
      check("R5 no ack after lost", ack_vec[5], 0);
      wait_start(idx, lat);
      check("R5 reselect picks newer urgent mb3", idx, 3);
      check_words("R2 buffer words mb3", 3);
      engine_done();
      wait_start(idx, lat);
      check("R5 retry of mb5", idx, 5);
      engine_done();
      check("R5 mb5 acked on retry", ack_vec[5], 1);
   endtask

   task automatic t_cancel();
      int idx, lat, seen;
      set_id(10, 'h300); set_id(11, 'h301); set_id(12, 'h302);
      reg_op(2'd0, (32'd1 << 10) | (32'd1 << 11));
      wait_start(idx, lat);
      check("R1 mb10 in flight", idx, 10);
      reg_op(2'd1, 32'd1 << 11);
      check("R6 idle cancel clears pend", pend_vec[11], 0);
      check("R6 idle cancel sets aback", aback_vec[11], 1);
      check("R6 idle cancel leaves cancel flag", cancel_vec, 0);
      reg_op(2'd1, 32'd1 << 10);
      check("R7 deferred cancel flag", cancel_vec, 32'd1 << 10);
      check("R7 in-flight stays pending", pend_vec[10], 1);
      engine_done();
      check("R7 sent despite cancel: ack", ack_vec[10], 1);
      check("R7 sent despite cancel: no aback", aback_vec[10], 0);
      check("R7 cancel flag cleared", cancel_vec, 0);
      reg_op(2'd0, 32'd1 << 12);
      wait_start(idx, lat);
      check("R1 mb12 in flight", idx, 12);
      reg_op(2'd1, 32'd1 << 12);
      engine_lost();
      check("R7 cancel+lost clears pend", pend_vec[12], 0);
      check("R7 cancel+lost sets aback", aback_vec[12], 1);
      check("R7 cancel+lost no ack", ack_vec[12], 0);
      check("R7 cancel flag cleared after lost", cancel_vec, 0);
      seen = 0;
      for (int c = 0; c < 10; c++) begin
         @(negedge clk);
         if (tx_start) seen++;
      end
      check("R3 no restart after cancelled loss", seen, 0);
   endtask

   task automatic t_cancel_nonpend();
      logic [NUM_MB-1:0] p0, a0, k0;
      p0 = pend_vec; a0 = aback_vec; k0 = ack_vec;
      reg_op(2'd1, 32'd1 << 30);
      check("R8 cancel on idle mb: cancel", cancel_vec, 0);
      check("R8 cancel on idle mb: aback", aback_vec, a0);
      check("R8 cancel on idle mb: pend", pend_vec, p0);
      check("R8 cancel on idle mb: ack", ack_vec, k0);
      reg_op(2'd3, 32'd1 << 11);
      check("R9 clear aback masked only", aback_vec, 32'd1 << 12);
   endtask

   task automatic t_ram();
      int stall, idx;
      // Idle write, granted in the same cycle.
      @(negedge clk);
      host_ram_req = 1'b1; host_ram_we = 1'b1;
      host_ram_addr = ADDR_W'(100); host_ram_wdata = 32'h1234_5678;
      #1;
      check("R10 idle grant", host_ram_gnt, 1);
      @(negedge clk);
      host_ram_req = 1'b0; host_ram_we = 1'b0;
      // Start a load, then read during it.
      set_id(0, 'h001);
      reg_op(2'd0, 32'd1 << 0);
      @(negedge clk);
      host_ram_req = 1'b1; host_ram_addr = ADDR_W'(100);
      stall = 0;
      #1;
      while (!host_ram_gnt && stall < 50) begin
         @(negedge clk);
         #1;
         stall++;
      end
      check("R10 controller holds RAM during load", stall > 0, 1);
      check("R11 stall within one load", stall <= WORDS, 1);
      idx = int'(tx_mb_idx);
      @(negedge clk);
      host_ram_req = 1'b0;
      check("R10 read valid", host_ram_rvalid, 1);
      check("R10 read data", ram_rdata, 32'h1234_5678);
      check("R2 load during host wait mb0", idx, 0);
      for (int k = 0; k < WORDS; k++)
         check("R2 buffer words mb0", cap[k], pat(k));
      engine_done();
      check("R4 ack mb0", ack_vec[0], 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_priority();
      t_idle_and_clear();
      t_lost();
      t_cancel();
      t_cancel_nonpend();
      t_ram();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         tests++;
         fails++;
         $display("FAIL watchdog: run hung, actual=%0d expected<=20000 cycles", cycles);
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule